// File: doc/BRIEF.md
# Interrupt Preemption and FIQ/IRQ Router

This block is the decision stage of an interrupt controller's CPU interface. Each cycle it receives the best pending interrupt: its priority, its group and a valid flag. It also receives the active-priority bit banks of the three groups, the binary point of each group, the two common-binary-point controls, the priority mask, the group enables, and the security state, exception level and register width of the CPU. From these inputs it decides whether the pending interrupt may preempt the work that is running. When it may, the block raises one of two lines, the fast line (FIQ) or the normal line (IRQ).

The running priority is rebuilt from the active-priority banks. Only the group-priority bits of the pending and running priorities are compared, so subpriority never causes preemption. The decision is made again from the present inputs every cycle. It appears on registered outputs one clock edge later. A change of CPU state therefore moves the line choice on the next edge.

Top module: `irq_preempt_router`

## Requirements
- R1: While the synchronous active-high reset is sampled high, both `fiq_o` and `irq_o` are low on the following cycle.
- R2: Outputs are registered, so the inputs present at a clock edge decide the outputs after that edge. At most one of `fiq_o` and `irq_o` is high at any time. Both are low whenever preemption is not possible.
- R3: Group encoding on `pend_grp_i` is 0 = Group 0, 1 = secure Group 1, 2 = non-secure Group 1. Nothing is signalled in any of these cases: `pend_valid_i` is low, the pending priority is 0xFF, the group is the illegal code 3, or the enable of the (effective) group is clear.
- R4: A pending interrupt whose priority is greater than or equal to `pmr_i` is not signalled.
- R5: The running priority is found as follows. The three active-priority banks are ORed together. The lowest set bit index among the lowest 2^(7-MIN_BPR) bits is taken and shifted left by MIN_BPR+1. Bits above that range are ignored. When no bit is set, the running priority is idle (0xFF). In that case an eligible, unmasked interrupt always preempts.
- R6: When something is running, preemption needs (pending & M) < (running & M), where M = 0xFF << (BPR+1). A BPR of 7 gives M = 0, so such an interrupt never preempts running work.
- R7: Secure Group 1 uses the Group 0 binary point when `cbpr_s_i` is set. Non-secure Group 1 uses the Group 0 binary point when `cbpr_ns_i` is set. Otherwise each group uses its own binary point.
- R8: When `has_top_el_i` is low, a secure Group 1 interrupt is treated as Group 0 for its enable, its binary point and its routing.
- R9: Group 0 is always routed to `fiq_o`.
- R10: Secure Group 1 is routed to `fiq_o` in two cases: the CPU is non-secure, or the CPU is at the top exception level in 64-bit state. In every other case it goes to `irq_o`.
- R11: Non-secure Group 1 is routed to `fiq_o` when the CPU is secure, and to `irq_o` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pend_valid_i | input | 1 | A pending interrupt is presented |
| pend_prio_i | input | 8 | Priority of the pending interrupt (lower is more urgent) |
| pend_grp_i | input | 2 | Group of the pending interrupt (0, 1, 2; 3 is illegal) |
| apr_g0_i | input | APR_WORDS*32 | Active-priority bank, Group 0 |
| apr_g1s_i | input | APR_WORDS*32 | Active-priority bank, secure Group 1 |
| apr_g1ns_i | input | APR_WORDS*32 | Active-priority bank, non-secure Group 1 |
| bpr_g0_i | input | 3 | Binary point, Group 0 |
| bpr_g1s_i | input | 3 | Binary point, secure Group 1 |
| bpr_g1ns_i | input | 3 | Binary point, non-secure Group 1 |
| cbpr_s_i | input | 1 | Secure Group 1 shares the Group 0 binary point |
| cbpr_ns_i | input | 1 | Non-secure Group 1 shares the Group 0 binary point |
| pmr_i | input | 8 | Priority mask |
| en_g0_i | input | 1 | Group 0 enable |
| en_g1s_i | input | 1 | Secure Group 1 enable |
| en_g1ns_i | input | 1 | Non-secure Group 1 enable |
| cpu_secure_i | input | 1 | CPU is in secure state |
| cpu_top_el_i | input | 1 | CPU is at the top exception level |
| cpu_top_el64_i | input | 1 | Top exception level runs in 64-bit state |
| has_top_el_i | input | 1 | CPU implements the top exception level |
| fiq_o | output | 1 | Fast interrupt line |
| irq_o | output | 1 | Normal interrupt line |

## Verification
The bench aims at the following edges. Each comes with the wrong behaviour it would expose:
- A pending priority equal to the mask. A design that compares with less-or-equal would raise a line here.
- Pending and running priorities that differ only in subpriority. A design that compares whole priorities would preempt wrongly.
- A binary point of 7. A design that lets the shift wrap would preempt here.
- Active bits set only above the meaningful range. A design that scans those bits would block an interrupt that should go through while the CPU is idle.
- Common-binary-point aliasing. A design that crosses the secure and non-secure controls would misbehave on those cases.
- Secure Group 1 on a CPU without the top level. A design that misses the demotion would use the wrong enable and the wrong route.
- The full route table across security state, level and width.

A reference model in the bench checks the outputs on every cycle, under both directed and random inputs.

// File: rtl/irq_preempt_router.sv
module irq_preempt_router #(
  parameter int MIN_BPR   = 3,
  parameter int APR_WORDS = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pend_valid_i,
  input  logic [7:0]              pend_prio_i,
  input  logic [1:0]              pend_grp_i,
  input  logic [APR_WORDS*32-1:0] apr_g0_i,
  input  logic [APR_WORDS*32-1:0] apr_g1s_i,
  input  logic [APR_WORDS*32-1:0] apr_g1ns_i,
  input  logic [2:0]              bpr_g0_i,
  input  logic [2:0]              bpr_g1s_i,
  input  logic [2:0]              bpr_g1ns_i,
  input  logic                    cbpr_s_i,
  input  logic                    cbpr_ns_i,
  input  logic [7:0]              pmr_i,
  input  logic                    en_g0_i,
  input  logic                    en_g1s_i,
  input  logic                    en_g1ns_i,
  input  logic                    cpu_secure_i,
  input  logic                    cpu_top_el_i,
  input  logic                    cpu_top_el64_i,
  input  logic                    has_top_el_i,
  output logic                    fiq_o,
  output logic                    irq_o
);
  localparam int APR_W  = APR_WORDS * 32;
  localparam int LEVELS = 1 << (7 - MIN_BPR);
  localparam int SCAN   = (LEVELS < APR_W) ? LEVELS : APR_W;
  localparam int SHIFT  = MIN_BPR + 1;

  logic [APR_W-1:0] apr_any;
  logic [7:0]       run_prio;
  logic             run_idle;
  logic [1:0]       eff_grp;
  logic             grp_en;
  logic [2:0]       bpr_sel;
  logic [7:0]       gmask;
  logic             eligible, unmasked, preempt, want_fiq;

  assign apr_any = apr_g0_i | apr_g1s_i | apr_g1ns_i;

  always_comb begin
    run_idle = 1'b1;
    run_prio = 8'hFF;
    for (int i = SCAN - 1; i >= 0; i--) begin
      if (apr_any[i]) begin
        run_idle = 1'b0;
        run_prio = 8'(i << SHIFT);
      end
    end
  end

  assign eff_grp = (pend_grp_i == 2'd1 && !has_top_el_i) ? 2'd0 : pend_grp_i;

  always_comb begin
    grp_en   = 1'b0;
    bpr_sel  = bpr_g0_i;
    want_fiq = 1'b0;
    case (eff_grp)
      2'd0: begin
        grp_en   = en_g0_i;
        want_fiq = 1'b1;
      end
      2'd1: begin
        grp_en   = en_g1s_i;
        bpr_sel  = cbpr_s_i ? bpr_g0_i : bpr_g1s_i;
        want_fiq = !cpu_secure_i || (cpu_top_el_i && cpu_top_el64_i);
      end
      2'd2: begin
        grp_en   = en_g1ns_i;
        bpr_sel  = cbpr_ns_i ? bpr_g0_i : bpr_g1ns_i;
        want_fiq = cpu_secure_i;
      end
      default: grp_en = 1'b0;
    endcase
  end

  assign gmask    = 8'hFF << ({1'b0, bpr_sel} + 4'd1);
  assign eligible = pend_valid_i && pend_prio_i != 8'hFF && grp_en;
  assign unmasked = pend_prio_i < pmr_i;
  assign preempt  = eligible && unmasked &&
                    (run_idle || ((pend_prio_i & gmask) < (run_prio & gmask)));

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      fiq_o <= preempt && want_fiq;
      irq_o <= preempt && !want_fiq;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!fiq_o && !irq_o));

  p_one_line_r2: assert property (@(posedge clk) disable iff (rst) !(fiq_o && irq_o));

  p_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (fiq_o || irq_o) |-> $past(pend_valid_i && pend_prio_i != 8'hFF && pend_grp_i != 2'd3));

  p_mask_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (fiq_o || irq_o) |-> $past(pend_prio_i < pmr_i));

  p_g0_fast_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_o && $past(pend_grp_i == 2'd0)) |-> 1'b0);

  p_g1ns_route_r11: assert property (@(posedge clk) disable iff (rst)
    (irq_o && $past(pend_grp_i == 2'd2)) |-> !$past(cpu_secure_i));
endmodule

// File: tb/sim_irq_preempt_router.sv
`timescale 1ns/1ps
module sim_irq_preempt_router;
  localparam int MIN_BPR = 3;
  localparam int APR_WORDS = 1;
  localparam int AW = APR_WORDS * 32;

  logic clk = 0, rst = 1;
  logic pend_valid_i;
  logic [7:0] pend_prio_i, pmr_i;
  logic [1:0] pend_grp_i;
  logic [AW-1:0] apr_g0_i, apr_g1s_i, apr_g1ns_i;
  logic [2:0] bpr_g0_i, bpr_g1s_i, bpr_g1ns_i;
  logic cbpr_s_i, cbpr_ns_i, en_g0_i, en_g1s_i, en_g1ns_i;
  logic cpu_secure_i, cpu_top_el_i, cpu_top_el64_i, has_top_el_i;
  logic fiq_o, irq_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_preempt_router #(.MIN_BPR(MIN_BPR), .APR_WORDS(APR_WORDS)) u0 (
    .clk(clk), .rst(rst), .pend_valid_i(pend_valid_i), .pend_prio_i(pend_prio_i),
    .pend_grp_i(pend_grp_i), .apr_g0_i(apr_g0_i), .apr_g1s_i(apr_g1s_i),
    .apr_g1ns_i(apr_g1ns_i), .bpr_g0_i(bpr_g0_i), .bpr_g1s_i(bpr_g1s_i),
    .bpr_g1ns_i(bpr_g1ns_i), .cbpr_s_i(cbpr_s_i), .cbpr_ns_i(cbpr_ns_i),
    .pmr_i(pmr_i), .en_g0_i(en_g0_i), .en_g1s_i(en_g1s_i), .en_g1ns_i(en_g1ns_i),
    .cpu_secure_i(cpu_secure_i), .cpu_top_el_i(cpu_top_el_i),
    .cpu_top_el64_i(cpu_top_el64_i), .has_top_el_i(has_top_el_i),
    .fiq_o(fiq_o), .irq_o(irq_o));

  function automatic void model(output bit ef, output bit ei);
    int levels, rp, grp, bp, en, m, pp;
    bit fast, go;
    ef = 0; ei = 0;
    if (rst) return;
    levels = 1 << (7 - MIN_BPR);
    rp = 255;
    for (int i = 0; i < levels && i < AW; i++)
      if (rp == 255 && (apr_g0_i[i] || apr_g1s_i[i] || apr_g1ns_i[i])) rp = i * (1 << (MIN_BPR + 1));
    grp = pend_grp_i;
    if (grp == 1 && !has_top_el_i) grp = 0;
    if (grp == 3) return;
    en = (grp == 0) ? en_g0_i : (grp == 1) ? en_g1s_i : en_g1ns_i;
    bp = (grp == 0) ? bpr_g0_i : (grp == 1) ? (cbpr_s_i ? bpr_g0_i : bpr_g1s_i)
                                            : (cbpr_ns_i ? bpr_g0_i : bpr_g1ns_i);
    pp = pend_prio_i;
    if (!pend_valid_i || pp == 255 || !en || pp >= pmr_i) return;
    m = (256 - (1 << (bp + 1))) & 255;
    go = (rp == 255) || ((pp & m) < (rp & m));
    if (!go) return;
    fast = (grp == 0) ? 1 : (grp == 1) ? (!cpu_secure_i || (cpu_top_el_i && cpu_top_el64_i))
                                       : cpu_secure_i;
    ef = fast; ei = !fast;
  endfunction

  task automatic step(input string req);
    bit ef, ei;
    model(ef, ei);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (fiq_o !== ef || irq_o !== ei) begin
      failures++;
      $display("FAIL %s: fiq/irq actual=%b%b expected=%b%b", req, fiq_o, irq_o, ef, ei);
    end
  endtask

  task automatic defaults();
    pend_valid_i = 1; pend_prio_i = 8'h40; pend_grp_i = 0; pmr_i = 8'hFF;
    apr_g0_i = '0; apr_g1s_i = '0; apr_g1ns_i = '0;
    bpr_g0_i = 0; bpr_g1s_i = 0; bpr_g1ns_i = 0; cbpr_s_i = 0; cbpr_ns_i = 0;
    en_g0_i = 1; en_g1s_i = 1; en_g1ns_i = 1;
    cpu_secure_i = 0; cpu_top_el_i = 0; cpu_top_el64_i = 0; has_top_el_i = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    defaults();
    @(negedge clk);
    step("R1"); step("R1");
    rst = 0;
    step("R9");
    pend_valid_i = 0; step("R3"); pend_valid_i = 1;
    pend_prio_i = 8'hFF; step("R3"); pend_prio_i = 8'h40;
    en_g0_i = 0; step("R3"); en_g0_i = 1;
    pend_grp_i = 3; step("R3"); pend_grp_i = 0;
    pmr_i = 8'h40; step("R4");
    pmr_i = 8'h41; step("R4"); pmr_i = 8'hFF;
    apr_g0_i[2] = 1; pend_prio_i = 8'h10; step("R5");
    pend_prio_i = 8'h20; step("R5");
    apr_g0_i = '0; apr_g1s_i[20] = 1; pend_prio_i = 8'hF0; step("R5");
    apr_g1s_i = '0; apr_g1ns_i[1] = 1; apr_g0_i[3] = 1; pend_prio_i = 8'h08; step("R5");
    pend_prio_i = 8'h10; step("R5");
    apr_g0_i = '0; apr_g1ns_i = '0; apr_g0_i[2] = 1; pend_prio_i = 8'h1F;
    bpr_g0_i = 4; step("R6");
    bpr_g0_i = 5; step("R6");
    bpr_g0_i = 7; step("R6");
    pend_prio_i = 8'h00; step("R6");
    bpr_g0_i = 5; bpr_g1s_i = 0; bpr_g1ns_i = 0; pend_prio_i = 8'h1F;
    pend_grp_i = 1; step("R7");
    cbpr_s_i = 1; step("R7");
    cbpr_s_i = 0; cbpr_ns_i = 1; step("R7");
    pend_grp_i = 2; step("R7");
    cbpr_ns_i = 0; step("R7");
    cbpr_s_i = 1; step("R7"); cbpr_s_i = 0;
    apr_g0_i = '0; bpr_g0_i = 0;
    pend_grp_i = 1; en_g1s_i = 0; has_top_el_i = 0; cpu_secure_i = 1; step("R8");
    has_top_el_i = 1; step("R8");
    en_g1s_i = 1; step("R10");
    cpu_secure_i = 0; step("R10");
    cpu_secure_i = 1; cpu_top_el_i = 1; cpu_top_el64_i = 1; step("R10");
    cpu_top_el64_i = 0; step("R10");
    cpu_top_el_i = 0; cpu_top_el64_i = 1; step("R10");
    pend_grp_i = 2; cpu_secure_i = 1; step("R11");
    cpu_secure_i = 0; step("R11");
    rst = 1; step("R1"); rst = 0;
    for (int n = 0; n < 2000; n++) begin
      pend_valid_i = ($urandom % 8) != 0;
      pend_prio_i = 8'($urandom); pend_grp_i = 2'($urandom);
      pmr_i = 8'($urandom | 32'h80);
      apr_g0_i = AW'($urandom & $urandom & $urandom & $urandom);
      apr_g1s_i = AW'($urandom & $urandom & $urandom & $urandom);
      apr_g1ns_i = AW'($urandom & $urandom & $urandom & $urandom);
      bpr_g0_i = 3'($urandom); bpr_g1s_i = 3'($urandom); bpr_g1ns_i = 3'($urandom);
      {cbpr_s_i, cbpr_ns_i, en_g0_i, en_g1s_i, en_g1ns_i} = 5'($urandom | 32'h7);
      {cpu_secure_i, cpu_top_el_i, cpu_top_el64_i, has_top_el_i} = 4'($urandom);
      step("R2");
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule